// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between two ports, A and B, in either direction. Each direction can pass the live data from the opposite port straight through, or it can drive a value held in a storage register. The data path is built from independent byte lanes. With the default parameters there are two lanes, so the block serves as two 8-bit transceivers or as one 16-bit path when the lane controls are tied together.

Each lane has six controls. Every direction has its own output enable, store strobe and source select. The enable toward B is active high and the enable toward A is active low, so one setting of the enables isolates both ports. Each port is split into an input vector, an output vector and a per-bit drive-enable vector. A surrounding harness resolves the real bus from these, including the loop-back case where a port reads back what the block itself drives.

Store strobes are synchronous to the system clock. A register loads its port's input on the clock edge at which its strobe is first seen high. The source select switches through a hazard-free mux, so when the live and stored bits agree the output holds steady across the switch.

Top module: `dual_bus_xcvr`

## Requirements
- R1: While `rst` is high, `a_oe` and `b_oe` are all zero regardless of the controls. After reset both storage registers hold zero, so a lane selecting stored data outputs 0x00 on both ports.
- R2: Port B is driven per lane by an active-high enable. For lane i, `b_oe[8i+7:8i]` is all ones when `ab_oe[i]`=1 and all zeros when `ab_oe[i]`=0.
- R3: Port A is driven per lane by an active-low enable. For lane i, `a_oe[8i+7:8i]` is all ones when `ba_oe_n[i]`=0 and all zeros when `ba_oe_n[i]`=1.
- R4: A select of 0 passes live data. With `ab_sel[i]`=0, lane i of `b_out` equals lane i of `a_in` in the same cycle. With `ba_sel[i]`=0, lane i of `a_out` equals lane i of `b_in`.
- R5: A select of 1 drives stored data. With `ab_sel[i]`=1, lane i of `b_out` shows the lane-i A-side register. With `ba_sel[i]`=1, lane i of `a_out` shows the lane-i B-side register. Each lane chooses its source on its own.
- R6: A storage register loads its port input on the clock edge at which its strobe is first seen high. It is visible right after that edge, whatever the enables and selects are. A strobe that stays high does not load again.
- R7: The lanes are independent. A strobe on one lane leaves the registers of the other lane unchanged.
- R8: Loop-back fill. With `ab_oe`=1, `ab_sel`=0 and the harness feeding `b_out` back into `b_in`, a simultaneous pulse of both strobes loads the A data into both registers. The mirror setting loads the B data into both registers: `ba_oe_n`=0, `ba_sel`=0 and `a_out` fed back into `a_in`.
- R9: With `ab_oe`=1, `ba_oe_n`=0 and both selects at 1, both ports drive at once. B shows stored A data and A shows stored B data.
- R10: When a select changes while the live and stored bits of that lane are equal, the output stays at that value. When they differ, the output moves directly from one source to the other.
- R11: With both selects at 0 in isolation, simultaneous strobes load each register with its own port's input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ab_oe | input | 2 | Per-lane enable for driving port B, active high |
| ba_oe_n | input | 2 | Per-lane enable for driving port A, active low |
| ab_stb | input | 2 | Per-lane store strobe for the A-side register |
| ba_stb | input | 2 | Per-lane store strobe for the B-side register |
| ab_sel | input | 2 | Per-lane source select toward B: 0 live, 1 stored |
| ba_sel | input | 2 | Per-lane source select toward A: 0 live, 1 stored |
| a_in | input | 16 | Resolved value seen on port A |
| a_out | output | 16 | Value the block offers to port A |
| a_oe | output | 16 | Per-bit drive enable for port A |
| b_in | input | 16 | Resolved value seen on port B |
| b_out | output | 16 | Value the block offers to port B |
| b_oe | output | 16 | Per-bit drive enable for port B |

## Verification
The bench uses the default build of two lanes of 8 bits each. With two lanes, a single vector can set the lanes to different modes: one lane live and the other stored, one lane enabled and the other idle, or a strobe on one lane only. These cases cover lane independence and per-lane select and enable decoding. The harness role is played by the bench, which feeds the driven value back into the same port for the loop-back fill cases. The hazard-free select is exercised by toggling a select between clock edges with live data equal to and then different from the stored byte.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Control bundle for one byte lane
    typedef struct packed {
        logic ab_oe;    // drive port B, active high
        logic ba_oe_n;  // drive port A, active low
        logic ab_stb;   // store strobe, A-side register
        logic ba_stb;   // store strobe, B-side register
        logic ab_sel;   // toward B: 0 live, 1 stored
        logic ba_sel;   // toward A: 0 live, 1 stored
    } lane_ctrl_t;

    // Drive-enable pair produced by a lane
    typedef struct packed {
        logic a_drv;
        logic b_drv;
    } lane_drive_t;

endpackage

// File: rtl/strobe_capture.sv
module strobe_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic         stb;
        logic [W-1:0] data;
    } cap_state_t;

    cap_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        // previous strobe level tracks the input even during reset
        state_d.stb = stb;
        if (rst) begin
            state_d.data = '0;
        end else if (stb && !state_q.stb) begin
            state_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign dout = state_q.data;

    // R6: a first-high strobe loads the input seen at that edge
    a_r6_load_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(stb) |=> dout == $past(din));

    // R6: without a new rising strobe the register keeps its value
    a_r6_hold_otherwise: assert property (@(posedge clk) disable iff (rst)
        !$rose(stb) |=> $stable(dout));

endmodule

// File: rtl/glitchless_sel.sv
module glitchless_sel #(
    parameter int W = 8
) (
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);

    logic [W-1:0] sel_v;

    always_comb begin
        sel_v = {W{sel}};
        // consensus term keeps equal bits steady while sel moves
        y = (sel_v & stored) | (~sel_v & live) | (stored & live);
    end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  lane_ctrl_t        ctrl,
    input  logic [LANE_W-1:0] a_in,
    input  logic [LANE_W-1:0] b_in,
    output logic [LANE_W-1:0] a_out,
    output logic [LANE_W-1:0] b_out,
    output logic              a_drv,
    output logic              b_drv
);

    logic [LANE_W-1:0] a_reg;
    logic [LANE_W-1:0] b_reg;
    lane_drive_t       drive;

    strobe_capture #(.W(LANE_W)) u_a_store (
        .clk  (clk),
        .rst  (rst),
        .stb  (ctrl.ab_stb),
        .din  (a_in),
        .dout (a_reg)
    );

    strobe_capture #(.W(LANE_W)) u_b_store (
        .clk  (clk),
        .rst  (rst),
        .stb  (ctrl.ba_stb),
        .din  (b_in),
        .dout (b_reg)
    );

    glitchless_sel #(.W(LANE_W)) u_to_b (
        .sel    (ctrl.ab_sel),
        .live   (a_in),
        .stored (a_reg),
        .y      (b_out)
    );

    glitchless_sel #(.W(LANE_W)) u_to_a (
        .sel    (ctrl.ba_sel),
        .live   (b_in),
        .stored (b_reg),
        .y      (a_out)
    );

    always_comb begin
        drive.b_drv = !rst && ctrl.ab_oe;
        drive.a_drv = !rst && !ctrl.ba_oe_n;
    end

    assign a_drv = drive.a_drv;
    assign b_drv = drive.b_drv;

    // R4: live select passes the opposite port straight through
    a_r4_live_to_b: assert property (@(posedge clk) disable iff (rst)
        !ctrl.ab_sel |-> b_out == a_in);

    // R5: stored select shows the register toward A
    a_r5_stored_to_a: assert property (@(posedge clk) disable iff (rst)
        ctrl.ba_sel |-> a_out == b_reg);

    // R10: a select flip with agreeing sources leaves the output alone
    a_r10_steady_switch: assert property (@(posedge clk) disable iff (rst)
        (ctrl.ab_sel != $past(ctrl.ab_sel)) && (a_in == a_reg)
        && $stable(a_in) && $stable(a_reg) |-> b_out == $past(b_out));

endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LANES-1:0]          ab_oe,
    input  logic [LANES-1:0]          ba_oe_n,
    input  logic [LANES-1:0]          ab_stb,
    input  logic [LANES-1:0]          ba_stb,
    input  logic [LANES-1:0]          ab_sel,
    input  logic [LANES-1:0]          ba_sel,
    input  logic [LANES*LANE_W-1:0]   a_in,
    output logic [LANES*LANE_W-1:0]   a_out,
    output logic [LANES*LANE_W-1:0]   a_oe,
    input  logic [LANES*LANE_W-1:0]   b_in,
    output logic [LANES*LANE_W-1:0]   b_out,
    output logic [LANES*LANE_W-1:0]   b_oe
);

    localparam int W = LANES * LANE_W;

    lane_ctrl_t       ctrl  [LANES];
    logic [LANES-1:0] a_drv;
    logic [LANES-1:0] b_drv;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            ctrl[i].ab_oe   = ab_oe[i];
            ctrl[i].ba_oe_n = ba_oe_n[i];
            ctrl[i].ab_stb  = ab_stb[i];
            ctrl[i].ba_stb  = ba_stb[i];
            ctrl[i].ab_sel  = ab_sel[i];
            ctrl[i].ba_sel  = ba_sel[i];
        end

        xcvr_lane #(.LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .ctrl  (ctrl[i]),
            .a_in  (a_in[i*LANE_W +: LANE_W]),
            .b_in  (b_in[i*LANE_W +: LANE_W]),
            .a_out (a_out[i*LANE_W +: LANE_W]),
            .b_out (b_out[i*LANE_W +: LANE_W]),
            .a_drv (a_drv[i]),
            .b_drv (b_drv[i])
        );

        assign a_oe[i*LANE_W +: LANE_W] = {LANE_W{a_drv[i]}};
        assign b_oe[i*LANE_W +: LANE_W] = {LANE_W{b_drv[i]}};
    end

    // R1: no port drives while reset is applied
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |-> (a_oe == '0) && (b_oe == '0));

    // R9: both directions can drive at the same time
    a_r9_both_drive: assert property (@(posedge clk) disable iff (rst)
        (ab_oe == '1) && (ba_oe_n == '0) |-> (a_oe == {W{1'b1}}) && (b_oe == {W{1'b1}}));

endmodule

// File: tb/dual_bus_xcvr_test.sv
module dual_bus_xcvr_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ab_oe = 2'b00, ba_oe_n = 2'b11;
    logic [1:0]  ab_stb = 2'b00, ba_stb = 2'b00;
    logic [1:0]  ab_sel = 2'b00, ba_sel = 2'b00;
    logic [15:0] a_in = 16'h0, b_in = 16'h0;
    logic [15:0] a_out, a_oe, b_out, b_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dual_bus_xcvr uut (
        .clk(clk), .rst(rst),
        .ab_oe(ab_oe), .ba_oe_n(ba_oe_n),
        .ab_stb(ab_stb), .ba_stb(ba_stb),
        .ab_sel(ab_sel), .ba_sel(ba_sel),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    typedef struct packed {
        logic [1:0]  ab_oe;
        logic [1:0]  ba_oe_n;
        logic [1:0]  ab_stb;
        logic [1:0]  ba_stb;
        logic [1:0]  ab_sel;
        logic [1:0]  ba_sel;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] exp_b;
        logic [15:0] exp_a;
        logic [1:0]  exp_boe;
        logic [1:0]  exp_aoe;
        logic [3:0]  req;
    } row_t;

    localparam int NROWS = 14;
    localparam row_t ROWS [NROWS] = '{
        // R4 isolation, live pass
        '{2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 16'h1234, 16'h5678, 16'h1234, 16'h5678, 2'b00, 2'b00, 4'd4},
        // R1 registers zero after reset
        '{2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 16'h1234, 16'h5678, 16'h0000, 16'h0000, 2'b00, 2'b00, 4'd1},
        // R6 rising strobe loads A register in isolation
        '{2'b00, 2'b11, 2'b11, 2'b00, 2'b11, 2'b11, 16'h1234, 16'h5678, 16'h1234, 16'h0000, 2'b00, 2'b00, 4'd6},
        // R6 held strobe does not reload
        '{2'b00, 2'b11, 2'b11, 2'b00, 2'b11, 2'b11, 16'h9999, 16'h5678, 16'h1234, 16'h0000, 2'b00, 2'b00, 4'd6},
        // R7 lane 0 B strobe only
        '{2'b00, 2'b11, 2'b00, 2'b01, 2'b11, 2'b11, 16'h9999, 16'hABCD, 16'h1234, 16'h00CD, 2'b00, 2'b00, 4'd7},
        // R9 stored both ways, both enabled
        '{2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 16'h0000, 16'hFFFF, 16'h1234, 16'h00CD, 2'b11, 2'b11, 4'd9},
        // R2 R3 mixed per-lane enables
        '{2'b01, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 16'h1357, 16'h2468, 16'h1357, 16'h2468, 2'b01, 2'b10, 4'd2},
        // R8 fill both from A (b_in fed from b_out)
        '{2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 16'hC3A5, 16'hC3A5, 16'hC3A5, 16'hC3A5, 2'b11, 2'b00, 4'd8},
        '{2'b11, 2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 16'h0000, 16'h0000, 16'hC3A5, 16'hC3A5, 2'b11, 2'b00, 4'd8},
        // R8 mirror fill from B (a_in fed from a_out)
        '{2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 16'h7E81, 16'h7E81, 16'h7E81, 16'h7E81, 2'b00, 2'b11, 4'd8},
        '{2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 16'h0000, 16'h0000, 16'h7E81, 16'h7E81, 2'b00, 2'b11, 4'd8},
        // R11 simultaneous strobes, live selects, isolation
        '{2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 16'h1111, 16'h2222, 16'h1111, 16'h2222, 2'b00, 2'b00, 4'd11},
        '{2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 16'h0000, 16'h0000, 16'h1111, 16'h2222, 2'b00, 2'b00, 4'd11},
        // R5 per-lane source choice
        '{2'b00, 2'b11, 2'b00, 2'b00, 2'b01, 2'b10, 16'hAAAA, 16'hBBBB, 16'hAA11, 16'h22BB, 2'b00, 2'b00, 4'd5}
    };

    function automatic logic [15:0] spread(input logic [1:0] lanes);
        return {{8{lanes[1]}}, {8{lanes[0]}}};
    endfunction

    task automatic chk(input string what, input int req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            finish_run();
        end
    end

    initial begin : stimulus
        // R1: enables forced low during reset even with controls asking to drive
        ab_oe   = 2'b11;
        ba_oe_n = 2'b00;
        repeat (3) @(posedge clk);
        #5;
        chk("b_oe in reset", 1, b_oe, 16'h0000);
        chk("a_oe in reset", 1, a_oe, 16'h0000);
        @(negedge clk);
        rst     = 1'b0;
        ab_oe   = 2'b00;
        ba_oe_n = 2'b11;

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            ab_oe   = ROWS[i].ab_oe;
            ba_oe_n = ROWS[i].ba_oe_n;
            ab_stb  = ROWS[i].ab_stb;
            ba_stb  = ROWS[i].ba_stb;
            ab_sel  = ROWS[i].ab_sel;
            ba_sel  = ROWS[i].ba_sel;
            a_in    = ROWS[i].a;
            b_in    = ROWS[i].b;
            @(posedge clk);
            #5;
            chk($sformatf("row %0d b_out", i), ROWS[i].req, b_out, ROWS[i].exp_b);
            chk($sformatf("row %0d a_out", i), ROWS[i].req, a_out, ROWS[i].exp_a);
            chk($sformatf("row %0d b_oe", i), 2, b_oe, spread(ROWS[i].exp_boe));
            chk($sformatf("row %0d a_oe", i), 3, a_oe, spread(ROWS[i].exp_aoe));
        end

        // R10: A register holds 16'h1111; live A equals it, select flips mid-cycle
        @(negedge clk);
        ab_sel = 2'b00;
        ba_sel = 2'b00;
        a_in   = 16'h1111;
        #1;
        chk("equal sources live", 10, b_out, 16'h1111);
        ab_sel = 2'b11;
        #1;
        chk("equal sources after flip", 10, b_out, 16'h1111);
        ab_sel = 2'b00;
        #1;
        chk("equal sources flip back", 10, b_out, 16'h1111);
        // R10: differing sources switch straight across
        a_in = 16'h5555;
        #1;
        chk("differing live", 10, b_out, 16'h5555);
        ab_sel = 2'b11;
        #1;
        chk("differing stored", 10, b_out, 16'h1111);

        // R1: reset in mid-run clears registers and drops enables
        @(negedge clk);
        ab_oe   = 2'b11;
        ba_oe_n = 2'b00;
        rst     = 1'b1;
        #1;
        chk("b_oe on reset", 1, b_oe, 16'h0000);
        chk("a_oe on reset", 1, a_oe, 16'h0000);
        @(negedge clk);
        rst    = 1'b0;
        ab_sel = 2'b11;
        ba_sel = 2'b11;
        #1;
        chk("A register cleared", 1, b_out, 16'h0000);
        chk("B register cleared", 1, a_out, 16'h0000);
        chk("b_oe after reset", 2, b_oe, 16'hFFFF);
        chk("a_oe after reset", 3, a_oe, 16'hFFFF);

        done = 1'b1;
        finish_run();
    end

endmodule